// File: doc/BRIEF.md
# Dual Mailbox Bypass Registers

This block gives two agents, each on its own clock, a way to hand each other a single word without going through the queue memory. It holds two independent mailboxes. One carries a word from the A side to the B side, and the other carries a word from B to A. The clocks `clk_a` and `clk_b` are unrelated.

A writer deposits a word in its outbound mailbox. A "mail waiting" flag then rises in the reader's clock domain, together with a stable copy of the word. When the reader consumes the word, the flag drops and the writer is released to send again. Set and release cross the clock boundary as toggle events through two-flop synchronizers. The reader latches the word only after it sees the synchronized toggle, so it never samples a changing word.

The data width follows the bus width selected for the B side. `bw_sel` is captured during master reset. A stored word keeps only the low 36, 18 or 9 bits and zeroes the rest.

Top module: `mbx_pair`

## Requirements
- R1: While `mrst` is high at clock edges of both domains, both flags, both busy outputs and both data outputs become 0.
- R2: A word written with `a_wr` while `a_busy` is low appears on `b_dout` with `b_mail` high within 8 `clk_b` cycles.
- R3: A word written with `b_wr` while `b_busy` is low appears on `a_dout` with `a_mail` high within 8 `clk_a` cycles.
- R4: A reader's flag and data hold steady until the reader pulses its read input. A read while the flag is high clears the flag. The flag never falls without such a read, except by reset.
- R5: A write while the writer's busy output is high is ignored. The pending word is neither overwritten nor followed by a second delivery.
- R6: `bw_sel` is sampled while `mrst` is high. 0 keeps all 36 bits, 1 keeps bits [17:0], and 2 or 3 keep bits [8:0]. All higher bits of the delivered word read 0.
- R7: A writer's busy output rises on an accepted write. It is already high when the reader's flag rises. It falls only after the reader's read, and the next write is then accepted.
- R8: A read pulse while the reader's flag is low has no effect. The flag stays low and the data output keeps its value.
- R9: The two mailboxes are independent. Writes in both directions in the same period are both delivered intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | A-side clock |
| clk_b | input | 1 | B-side clock, asynchronous to clk_a |
| mrst | input | 1 | Master reset, active high, sampled synchronously in each domain |
| bw_sel | input | 2 | B-bus width select, captured during reset |
| a_wr | input | 1 | A-side write strobe for the A-to-B mailbox |
| a_din | input | 36 | A-side write word |
| a_busy | output | 1 | A-to-B mailbox holds unread mail (writes ignored) |
| b_rd | input | 1 | B-side read strobe for the A-to-B mailbox |
| b_dout | output | 36 | Word delivered to the B side |
| b_mail | output | 1 | New mail waiting for the B side |
| b_wr | input | 1 | B-side write strobe for the B-to-A mailbox |
| b_din | input | 36 | B-side write word |
| b_busy | output | 1 | B-to-A mailbox holds unread mail (writes ignored) |
| a_rd | input | 1 | A-side read strobe for the B-to-A mailbox |
| a_dout | output | 36 | Word delivered to the A side |
| a_mail | output | 1 | New mail waiting for the A side |

## Verification
The delicate coincidence is inside one mailbox. A reader's read clears its flag in the same period in which the writer tries to push a second word. The writer is still busy until the acknowledge crosses back, so that second word must vanish. The bench waits for the flag, issues the extra write, and reads the mailbox. It then judges that the first word was the one seen and that no second flag ever rises. A second overlap fires writes in both directions in one period and checks that each side receives its own word.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int MBX_DW = 36;

    typedef enum logic [1:0] {
        BW_FULL  = 2'd0,
        BW_HALF  = 2'd1,
        BW_QTR   = 2'd2,
        BW_QTR_X = 2'd3
    } bw_mode_e;

    typedef struct packed {
        logic busy;
        logic req_tog;
        logic ack_seen;
    } wr_state_t;

    typedef struct packed {
        logic mail;
        logic req_seen;
        logic ack_tog;
    } rd_state_t;

endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
    import mbx_pkg::*;
#(
    parameter int DATA_W      = MBX_DW,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              mrst,
    input  logic [1:0]        bw_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] din,
    output logic              busy,
    input  logic              rd_en,
    output logic [DATA_W-1:0] dout,
    output logic              mail
);
    localparam int HALF_W = DATA_W / 2;
    localparam int QTR_W  = DATA_W / 4;

    bw_mode_e          cfg_w;
    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] hold_q;
    wr_state_t         ws;
    rd_state_t         rs;
    logic [DATA_W-1:0] dout_q;
    logic              req_s;
    logic              ack_s;

    always_comb begin
        case (cfg_w)
            BW_FULL: keep_mask = '1;
            BW_HALF: keep_mask = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
            default: keep_mask = {{(DATA_W-QTR_W){1'b0}}, {QTR_W{1'b1}}};
        endcase
    end

    // writer domain
    always_ff @(posedge wclk) begin
        if (mrst) begin
            cfg_w  <= bw_mode_e'(bw_sel);
            hold_q <= '0;
            ws     <= '0;
        end else if (ack_s != ws.ack_seen) begin
            ws.ack_seen <= ack_s;
            ws.busy     <= 1'b0;
        end else if (wr_en && !ws.busy) begin
            hold_q     <= din & keep_mask;
            ws.req_tog <= ~ws.req_tog;
            ws.busy    <= 1'b1;
        end
    end

    mbx_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (rclk),
        .rst (mrst),
        .d   (ws.req_tog),
        .q   (req_s)
    );

    // reader domain
    always_ff @(posedge rclk) begin
        if (mrst) begin
            rs     <= '0;
            dout_q <= '0;
        end else if (req_s != rs.req_seen) begin
            rs.req_seen <= req_s;
            rs.mail     <= 1'b1;
            dout_q      <= hold_q;
        end else if (rd_en && rs.mail) begin
            rs.mail    <= 1'b0;
            rs.ack_tog <= ~rs.ack_tog;
        end
    end

    mbx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (wclk),
        .rst (mrst),
        .d   (rs.ack_tog),
        .q   (ack_s)
    );

    assign busy = ws.busy;
    assign mail = rs.mail;
    assign dout = dout_q;
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
    import mbx_pkg::*;
#(
    parameter int DATA_W      = MBX_DW,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_a,
    input  logic              clk_b,
    input  logic              mrst,
    input  logic [1:0]        bw_sel,
    input  logic              a_wr,
    input  logic [DATA_W-1:0] a_din,
    output logic              a_busy,
    input  logic              b_rd,
    output logic [DATA_W-1:0] b_dout,
    output logic              b_mail,
    input  logic              b_wr,
    input  logic [DATA_W-1:0] b_din,
    output logic              b_busy,
    input  logic              a_rd,
    output logic [DATA_W-1:0] a_dout,
    output logic              a_mail
);
    localparam int N_BOX = 2;

    logic [N_BOX-1:0]             wclk, rclk, wr, rd, busy, mail;
    logic [N_BOX-1:0][DATA_W-1:0] wdat, rdat;

    // box 0 carries A to B, box 1 carries B to A
    assign wclk = {clk_b, clk_a};
    assign rclk = {clk_a, clk_b};
    assign wr   = {b_wr, a_wr};
    assign rd   = {a_rd, b_rd};
    assign wdat = {b_din, a_din};

    generate
        for (genvar i = 0; i < N_BOX; i++) begin : g_box
            mbx_channel #(
                .DATA_W      (DATA_W),
                .SYNC_STAGES (SYNC_STAGES)
            ) u_ch (
                .wclk   (wclk[i]),
                .rclk   (rclk[i]),
                .mrst   (mrst),
                .bw_sel (bw_sel),
                .wr_en  (wr[i]),
                .din    (wdat[i]),
                .busy   (busy[i]),
                .rd_en  (rd[i]),
                .dout   (rdat[i]),
                .mail   (mail[i])
            );
        end
    endgenerate

    assign a_busy = busy[0];
    assign b_mail = mail[0];
    assign b_dout = rdat[0];
    assign b_busy = busy[1];
    assign a_mail = mail[1];
    assign a_dout = rdat[1];
endmodule

// File: rtl/mbx_pair_checker.sv
module mbx_pair_checker #(
    parameter int DATA_W = 36
) (
    input logic              clk_a,
    input logic              clk_b,
    input logic              mrst,
    input logic [1:0]        bw_sel,
    input logic              a_busy,
    input logic              b_rd,
    input logic [DATA_W-1:0] b_dout,
    input logic              b_mail,
    input logic              b_busy,
    input logic              a_rd,
    input logic [DATA_W-1:0] a_dout,
    input logic              a_mail
);
    localparam int QW = DATA_W / 4;
    localparam int HW = DATA_W / 2;

    logic [1:0] sel_q;
    always_ff @(posedge clk_b) if (mrst) sel_q <= bw_sel;

    p_reset_b_r1: assert property (@(posedge clk_b) mrst |=> !b_mail && b_dout == '0);
    p_reset_a_r1: assert property (@(posedge clk_a) mrst |=> !a_mail && a_dout == '0);

    p_hold_b_r4: assert property (@(posedge clk_b) disable iff (mrst)
        b_mail && !b_rd |=> b_mail && $stable(b_dout));
    p_hold_a_r4: assert property (@(posedge clk_a) disable iff (mrst)
        a_mail && !a_rd |=> a_mail && $stable(a_dout));

    p_clear_b_r4: assert property (@(posedge clk_b) disable iff (mrst)
        $fell(b_mail) |-> $past(b_rd));
    p_clear_a_r4: assert property (@(posedge clk_a) disable iff (mrst)
        $fell(a_mail) |-> $past(a_rd));

    p_busy_b_r7: assert property (@(posedge clk_b) disable iff (mrst)
        $rose(b_mail) |-> a_busy);
    p_busy_a_r7: assert property (@(posedge clk_a) disable iff (mrst)
        $rose(a_mail) |-> b_busy);

    p_mask_qtr_r6: assert property (@(posedge clk_b) disable iff (mrst)
        b_mail && sel_q[1] |-> b_dout[DATA_W-1:QW] == '0);
    p_mask_half_r6: assert property (@(posedge clk_b) disable iff (mrst)
        b_mail && sel_q == 2'd1 |-> b_dout[DATA_W-1:HW] == '0);
endmodule

bind mbx_pair mbx_pair_checker #(.DATA_W(DATA_W)) u_chk (
    .clk_a  (clk_a),
    .clk_b  (clk_b),
    .mrst   (mrst),
    .bw_sel (bw_sel),
    .a_busy (a_busy),
    .b_rd   (b_rd),
    .b_dout (b_dout),
    .b_mail (b_mail),
    .b_busy (b_busy),
    .a_rd   (a_rd),
    .a_dout (a_dout),
    .a_mail (a_mail)
);

// File: tb/mbx_pair_bench.sv
module mbx_pair_bench;
    localparam int W = 36;

    logic clk_a = 0, clk_b = 0, mrst = 1;
    logic [1:0] bw_sel = 2'd0;
    logic a_wr = 0, b_wr = 0, a_rd = 0, b_rd = 0;
    logic [W-1:0] a_din = '0, b_din = '0;
    logic a_busy, b_busy, a_mail, b_mail;
    logic [W-1:0] a_dout, b_dout;
    int n_chk = 0, n_bad = 0;

    always #4   clk_a = ~clk_a;
    always #5.5 clk_b = ~clk_b;

    mbx_pair u_mbx_pair (.*);

    // {direction (0: A to B, 1: B to A), word}
    localparam logic [W:0] VEC [6] = '{
        {1'b0, 36'h1_2345_6789}, {1'b1, 36'hF_EDCB_A987},
        {1'b0, 36'h0_0000_0001}, {1'b1, 36'h8_0000_0000},
        {1'b0, 36'hF_FFFF_FFFF}, {1'b1, 36'h5_A5A5_A5A5}
    };

    task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] sel);
        @(negedge clk_a); mrst = 1; bw_sel = sel;
        repeat (4) @(negedge clk_b);
        repeat (4) @(negedge clk_a);
        mrst = 0;
        repeat (2) @(negedge clk_b);
    endtask

    task automatic wr_a(input logic [W-1:0] d);
        @(negedge clk_a); a_wr = 1; a_din = d;
        @(negedge clk_a); a_wr = 0;
    endtask

    task automatic wr_b(input logic [W-1:0] d);
        @(negedge clk_b); b_wr = 1; b_din = d;
        @(negedge clk_b); b_wr = 0;
    endtask

    task automatic rd_b();
        @(negedge clk_b); b_rd = 1;
        @(negedge clk_b); b_rd = 0;
    endtask

    task automatic rd_a();
        @(negedge clk_a); a_rd = 1;
        @(negedge clk_a); a_rd = 0;
    endtask

    task automatic wait_b_mail(output bit got);
        got = 0;
        for (int i = 0; i < 8 && !got; i++) begin
            @(negedge clk_b);
            got = b_mail;
        end
    endtask

    task automatic wait_a_mail(output bit got);
        got = 0;
        for (int i = 0; i < 8 && !got; i++) begin
            @(negedge clk_a);
            got = a_mail;
        end
    endtask

    task automatic settle();
        repeat (12) @(negedge clk_b);
    endtask

    task automatic send_ab(input logic [W-1:0] d, input logic [W-1:0] exp, input string req);
        bit got;
        wr_a(d);
        wait_b_mail(got);
        chk(got, req, {35'b0, got}, 36'd1);
        chk(b_dout == exp, req, b_dout, exp);
        rd_b();
        chk(!b_mail, "R4 flag cleared by read", {35'b0, b_mail}, 36'd0);
        settle();
        chk(!a_busy, "R7 busy released after read", {35'b0, a_busy}, 36'd0);
    endtask

    task automatic send_ba(input logic [W-1:0] d, input string req);
        bit got;
        wr_b(d);
        wait_a_mail(got);
        chk(got, req, {35'b0, got}, 36'd1);
        chk(a_dout == d, req, a_dout, d);
        rd_a();
        chk(!a_mail, "R4 flag cleared by read", {35'b0, a_mail}, 36'd0);
        settle();
        chk(!b_busy, "R7 busy released after read", {35'b0, b_busy}, 36'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk_a);
        n_bad++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit got;
        logic [W-1:0] prev;
        do_reset(2'd0);
        // R1 reset state
        chk(!a_mail && !b_mail, "R1 flags low", {34'b0, a_mail, b_mail}, 36'd0);
        chk(!a_busy && !b_busy, "R1 busy low", {34'b0, a_busy, b_busy}, 36'd0);
        chk(a_dout == 0 && b_dout == 0, "R1 data zero", a_dout | b_dout, 36'd0);

        // table of transfers, R2 and R3
        foreach (VEC[i]) begin
            if (VEC[i][W]) send_ba(VEC[i][W-1:0], "R3 B-to-A delivery");
            else           send_ab(VEC[i][W-1:0], VEC[i][W-1:0], "R2 A-to-B delivery");
        end

        // R4 hold without read, R5 write while busy ignored
        wr_a(36'hA_1111_1111);
        wait_b_mail(got);
        chk(got, "R2 delivery", {35'b0, got}, 36'd1);
        chk(a_busy, "R7 busy while mail pending", {35'b0, a_busy}, 36'd1);
        fork
            wr_a(36'hB_2222_2222);
            rd_b();
        join
        chk(b_dout == 36'hA_1111_1111, "R5 pending word kept", b_dout, 36'hA_1111_1111);
        settle();
        chk(!b_mail, "R5 ignored write not delivered", {35'b0, b_mail}, 36'd0);
        chk(b_dout == 36'hA_1111_1111, "R5 data unchanged", b_dout, 36'hA_1111_1111);

        // R4 flag holds across idle cycles
        wr_b(36'h3_3333_3333);
        wait_a_mail(got);
        repeat (10) @(negedge clk_a);
        chk(a_mail && a_dout == 36'h3_3333_3333, "R4 flag holds until read", a_dout, 36'h3_3333_3333);
        rd_a();
        settle();

        // R8 read without mail
        prev = b_dout;
        rd_b();
        repeat (3) @(negedge clk_b);
        chk(!b_mail, "R8 empty read keeps flag low", {35'b0, b_mail}, 36'd0);
        chk(b_dout == prev, "R8 empty read keeps data", b_dout, prev);
        send_ab(36'h7_0F0F_0F0F, 36'h7_0F0F_0F0F, "R7 next write accepted");

        // R9 both directions at once
        fork
            wr_a(36'hC_CCCC_0001);
            wr_b(36'hD_DDDD_0002);
        join
        repeat (8) @(negedge clk_b);
        chk(b_mail && b_dout == 36'hC_CCCC_0001, "R9 A-to-B concurrent", b_dout, 36'hC_CCCC_0001);
        chk(a_mail && a_dout == 36'hD_DDDD_0002, "R9 B-to-A concurrent", a_dout, 36'hD_DDDD_0002);
        fork
            rd_a();
            rd_b();
        join
        settle();

        // R6 width modes
        do_reset(2'd1);
        send_ab(36'hF_FFFF_FFFF, 36'h0_0003_FFFF, "R6 half width");
        do_reset(2'd2);
        send_ab(36'hF_FFFF_FFFF, 36'h0_0000_01FF, "R6 quarter width");
        do_reset(2'd3);
        send_ab(36'hA_BCDE_F123, 36'h0_0000_0123, "R6 quarter width alt code");
        do_reset(2'd0);
        send_ab(36'hA_BCDE_F123, 36'hA_BCDE_F123, "R6 full width");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule